// File: doc/BRIEF.md
# Bulk Flash Programming Sequencer

This block sits on the programmer side of a flash device and drives it through its buffered bulk-programming mode. Given a block base address and a stream of 16-bit words from a valid/ready source, it writes the setup and confirm commands, waits out the device's startup time, and polls the status byte. While it polls it only reads, and never writes a status command. Once the device reports its write buffer free, the block streams exactly one buffer of words at the held block address. The last buffer is padded with all-ones words once the source marks its final word. The block checks status between buffers.

When the data is used up, the sequencer leaves the mode by writing to a different address. It then polls until the device reports ready, and pulses `done` with the final status byte and an error code. The cases it reports are: a misaligned base address, a failure flagged by the device (with lock and voltage causes shown separately), and a stream that would run past the end of the block.

Top module: `flash_bulk_seq`

## Requirements
- R1: A start whose base address has any of its low log2(BURST) bits set (bits [8:0] by default) performs no flash access. `done` pulses in the cycle after the start, with `err_code` = 1.
- R2: An aligned start first writes SETUP_CMD (0x80), then CONFIRM_CMD (0xD0) in the next cycle, both at the base address.
- R3: After confirm, no status read is issued for at least STARTUP_DELAY cycles. Status is obtained only by `fl_re` read strobes, and no write is ever issued in the same cycle as a read. Only setup, confirm, data and exit writes appear on the bus.
- R4: Data words are written only after the latest status read showed bit 7 clear and bit 0 set. `in_ready` is low at all other times.
- R5: Each buffer is exactly BURST (512) consecutive data writes, carrying the source words in order. After the word flagged `in_last`, the rest of that buffer is filled with 0xFFFF.
- R6: Every data write is issued at the unchanged base address.
- R7: A status read with bit 4 set ends the job at once, with no further writes. `err_code` is set to 2, `status` to the byte read, `lock_fault` to bit 1 and `volt_fault` to bit 3.
- R8: If the block (BLOCK_WORDS words) is full and the source has not yet given its last word, `err_code` is set to 3. The word is not accepted, and the mode is exited.
- R9: The exit is one write at base address + 1. The block then polls until bit 7 is set. `done` pulses for one cycle, `status` holds that final byte, and `err_code` is 0 on success.
- R10: After reset, `done`, `busy`, `fl_we`, `fl_re` and `in_ready` are low and `err_code` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a job with the given base address |
| base_addr | input | AW | Block first-word address |
| in_valid | input | 1 | Source word valid |
| in_ready | output | 1 | Sequencer accepts a word this cycle |
| in_data | input | DW | Source word |
| in_last | input | 1 | Marks the final source word |
| fl_addr | output | AW | Flash address |
| fl_wdata | output | DW | Flash write data |
| fl_we | output | 1 | One-cycle write strobe |
| fl_re | output | 1 | One-cycle read strobe; status returns the next cycle |
| fl_rdata | input | 8 | Status byte from flash |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| err_code | output | 2 | 0 none, 1 misaligned, 2 device failure, 3 block overflow |
| status | output | 8 | Final status byte captured |
| lock_fault | output | 1 | Device failure caused by a locked block |
| volt_fault | output | 1 | Device failure caused by programming voltage |

## Verification
The main function is tried with several stream lengths:
- 300 words, which is a partial single buffer and shows that padding starts at the right word.
- 700 words with source bubbles and a busy interval between buffers, which separates correct hold-off from writes issued while the buffer is unavailable.
- Exactly 512 words, which shows that a last word landing on a buffer boundary adds no padded buffer.
- 1100 words into a 1024-word block, which exercises the overflow exit.

Injected status bytes at setup (0x12 and 0x18) and after the first buffer (0x10) show that each failure cause is reported apart from the others and that the bus goes quiet.

// File: rtl/fbp_pkg.sv
package fbp_pkg;
  localparam int SR_W     = 8;
  localparam int SR_READY = 7;
  localparam int SR_FAIL  = 4;
  localparam int SR_VOLT  = 3;
  localparam int SR_LOCK  = 1;
  localparam int SR_AVAIL = 0;

  typedef enum logic [3:0] {
    S_IDLE, S_SETUP, S_CONFIRM, S_WAIT, S_RD, S_RDW, S_CHK, S_LOAD, S_EXIT
  } seq_state_t;

  typedef enum logic [1:0] {
    E_NONE = 2'd0, E_ALIGN = 2'd1, E_DEVICE = 2'd2, E_OVF = 2'd3
  } seq_err_t;

  typedef enum logic [1:0] {
    D_WAIT, D_GO, D_FAIL
  } poll_dec_t;
endpackage

// File: rtl/fbp_delay_timer.sv
module fbp_delay_timer #(
  parameter int DELAY = 64,
  localparam int W = $clog2(DELAY + 2)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic expired
);
  logic [W-1:0] cnt;
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (start) begin
      cnt   <= W'(DELAY);
      armed <= 1'b1;
    end else if (armed && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = armed && (cnt == '0) && !start;

  // R3: the wait cannot end in the cycle right after it is armed
  p_delay_min_r3: assert property (@(posedge clk) disable iff (rst)
    (start && DELAY > 0) |=> !expired);
endmodule

// File: rtl/fbp_word_counters.sv
module fbp_word_counters #(
  parameter int BURST       = 512,
  parameter int BLOCK_WORDS = 65536,
  localparam int BCW = $clog2(BURST),
  localparam int TCW = $clog2(BLOCK_WORDS + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clear,
  input  logic           step,
  output logic [BCW-1:0] burst_idx,
  output logic           burst_end,
  output logic [TCW-1:0] total,
  output logic           block_full
);
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      burst_idx <= '0;
      total     <= '0;
    end else if (step) begin
      burst_idx <= (burst_idx == BCW'(BURST - 1)) ? '0 : burst_idx + 1'b1;
      total     <= total + 1'b1;
    end
  end

  assign burst_end  = (burst_idx == BCW'(BURST - 1));
  assign block_full = (total == TCW'(BLOCK_WORDS));

  // R5: a buffer closes after exactly BURST words
  p_burst_wrap_r5: assert property (@(posedge clk) disable iff (rst || clear)
    (step && burst_end) |=> (burst_idx == '0));
  // R8: never more words than the block holds
  p_total_cap_r8: assert property (@(posedge clk) disable iff (rst)
    total <= TCW'(BLOCK_WORDS));
endmodule

// File: rtl/fbp_status_eval.sv
module fbp_status_eval
  import fbp_pkg::*;
(
  input  logic      exit_phase,
  input  logic      sr_ready,
  input  logic      sr_fail,
  input  logic      sr_avail,
  output poll_dec_t dec
);
  always_comb begin
    if (sr_fail)
      dec = D_FAIL;
    else if (exit_phase)
      dec = sr_ready ? D_GO : D_WAIT;
    else
      dec = (!sr_ready && sr_avail) ? D_GO : D_WAIT;
  end
endmodule

// File: rtl/flash_bulk_seq.sv
module flash_bulk_seq
  import fbp_pkg::*;
#(
  parameter int AW            = 24,
  parameter int DW            = 16,
  parameter int BURST         = 512,
  parameter int BLOCK_WORDS   = 65536,
  parameter int STARTUP_DELAY = 64,
  parameter logic [DW-1:0] SETUP_CMD   = DW'('h80),
  parameter logic [DW-1:0] CONFIRM_CMD = DW'('hD0),
  localparam int AL  = $clog2(BURST),
  localparam int BCW = $clog2(BURST),
  localparam int TCW = $clog2(BLOCK_WORDS + 1),
  localparam logic [DW-1:0] PAD = {DW{1'b1}}
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] base_addr,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          in_last,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_wdata,
  output logic          fl_we,
  output logic          fl_re,
  input  logic [SR_W-1:0] fl_rdata,
  output logic          busy,
  output logic          done,
  output logic [1:0]    err_code,
  output logic [SR_W-1:0] status,
  output logic          lock_fault,
  output logic          volt_fault
);
  seq_state_t state;
  seq_err_t   err_q;
  logic [AW-1:0] base_q, addr_q;
  logic [DW-1:0] wdata_q;
  logic we_q, re_q, done_q, busy_q, lock_q, volt_q;
  logic src_done, exit_ph;
  logic [SR_W-1:0] status_q;

  logic           tmr_start, tmr_expired;
  logic           cnt_clear, step;
  logic [BCW-1:0] burst_idx;
  logic           burst_end, block_full;
  logic [TCW-1:0] total;
  poll_dec_t      dec;

  assign tmr_start = (state == S_CONFIRM);
  assign cnt_clear = (state == S_IDLE) && start;
  assign step      = (state == S_LOAD) && (src_done || in_valid);
  assign in_ready  = (state == S_LOAD) && !src_done;

  fbp_delay_timer #(.DELAY(STARTUP_DELAY)) u_timer (
    .clk(clk), .rst(rst), .start(tmr_start), .expired(tmr_expired)
  );

  fbp_word_counters #(.BURST(BURST), .BLOCK_WORDS(BLOCK_WORDS)) u_cnt (
    .clk(clk), .rst(rst), .clear(cnt_clear), .step(step),
    .burst_idx(burst_idx), .burst_end(burst_end),
    .total(total), .block_full(block_full)
  );

  fbp_status_eval u_eval (
    .exit_phase(exit_ph),
    .sr_ready(fl_rdata[SR_READY]),
    .sr_fail(fl_rdata[SR_FAIL]),
    .sr_avail(fl_rdata[SR_AVAIL]),
    .dec(dec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      err_q    <= E_NONE;
      base_q   <= '0;
      addr_q   <= '0;
      wdata_q  <= '0;
      we_q     <= 1'b0;
      re_q     <= 1'b0;
      done_q   <= 1'b0;
      busy_q   <= 1'b0;
      lock_q   <= 1'b0;
      volt_q   <= 1'b0;
      src_done <= 1'b0;
      exit_ph  <= 1'b0;
      status_q <= '0;
    end else begin
      we_q   <= 1'b0;
      re_q   <= 1'b0;
      done_q <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            base_q   <= base_addr;
            addr_q   <= base_addr;
            lock_q   <= 1'b0;
            volt_q   <= 1'b0;
            status_q <= '0;
            src_done <= 1'b0;
            exit_ph  <= 1'b0;
            if (base_addr[AL-1:0] != '0) begin
              err_q  <= E_ALIGN;
              done_q <= 1'b1;
            end else begin
              err_q  <= E_NONE;
              busy_q <= 1'b1;
              state  <= S_SETUP;
            end
          end
        end
        S_SETUP: begin
          we_q    <= 1'b1;
          addr_q  <= base_q;
          wdata_q <= SETUP_CMD;
          state   <= S_CONFIRM;
        end
        S_CONFIRM: begin
          we_q    <= 1'b1;
          addr_q  <= base_q;
          wdata_q <= CONFIRM_CMD;
          state   <= S_WAIT;
        end
        S_WAIT: begin
          if (tmr_expired) state <= S_RD;
        end
        S_RD: begin
          re_q   <= 1'b1;
          addr_q <= base_q;
          state  <= S_RDW;
        end
        S_RDW: state <= S_CHK;
        S_CHK: begin
          case (dec)
            D_FAIL: begin
              err_q    <= E_DEVICE;
              status_q <= fl_rdata;
              lock_q   <= fl_rdata[SR_LOCK];
              volt_q   <= fl_rdata[SR_VOLT];
              done_q   <= 1'b1;
              busy_q   <= 1'b0;
              state    <= S_IDLE;
            end
            D_GO: begin
              if (exit_ph) begin
                status_q <= fl_rdata;
                done_q   <= 1'b1;
                busy_q   <= 1'b0;
                state    <= S_IDLE;
              end else if (src_done) begin
                state <= S_EXIT;
              end else if (block_full) begin
                err_q <= E_OVF;
                state <= S_EXIT;
              end else begin
                state <= S_LOAD;
              end
            end
            default: state <= S_RD;
          endcase
        end
        S_LOAD: begin
          if (src_done || in_valid) begin
            we_q    <= 1'b1;
            addr_q  <= base_q;
            wdata_q <= src_done ? PAD : in_data;
            if (!src_done && in_last) src_done <= 1'b1;
            if (burst_end) state <= S_RD;
          end
        end
        S_EXIT: begin
          we_q    <= 1'b1;
          addr_q  <= base_q + AW'(1);
          wdata_q <= PAD;
          exit_ph <= 1'b1;
          state   <= S_RD;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign fl_addr    = addr_q;
  assign fl_wdata   = wdata_q;
  assign fl_we      = we_q;
  assign fl_re      = re_q;
  assign busy       = busy_q;
  assign done       = done_q;
  assign err_code   = err_q;
  assign status     = status_q;
  assign lock_fault = lock_q;
  assign volt_fault = volt_q;

  // R1: only aligned bases reach the command phase
  p_align_r1: assert property (@(posedge clk) disable iff (rst)
    (state == S_SETUP) |-> (base_q[AL-1:0] == '0));
  // R2: confirm follows setup on the next cycle
  p_cmd_pair_r2: assert property (@(posedge clk) disable iff (rst)
    (state == S_WAIT && $past(state) == S_CONFIRM) |->
      (fl_we && fl_wdata == CONFIRM_CMD && $past(fl_we) && $past(fl_wdata) == SETUP_CMD));
  // R3: reads and writes never share a cycle
  p_rw_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(fl_we && fl_re));
  // R4: the source is released only after a status check that allowed it
  p_hold_off_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(in_ready) |-> $past(state == S_CHK && dec == D_GO));
  // R6: data writes stay on the block's first-word address
  p_addr_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (fl_we && $past(state == S_LOAD)) |-> (fl_addr == base_q));
  // R7: once idle the bus stays quiet
  p_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE) |=> (!fl_we && !fl_re));
  // R9: done is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: tb/flash_bulk_seq_test.sv
module flash_bulk_seq_test;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int BW = 1024;
  localparam int DLY = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic in_last = 1'b0;
  logic in_ready;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_wdata;
  logic fl_we, fl_re;
  logic [7:0] fl_rdata = 8'h80;
  logic busy, done, lock_fault, volt_fault;
  logic [1:0] err_code;
  logic [7:0] status;

  always #5 clk = ~clk;

  flash_bulk_seq #(.AW(AW), .DW(DW), .BLOCK_WORDS(BW), .STARTUP_DELAY(DLY)) uut (
    .clk(clk), .rst(rst), .start(start), .base_addr(base_addr),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_re(fl_re),
    .fl_rdata(fl_rdata), .busy(busy), .done(done), .err_code(err_code),
    .status(status), .lock_fault(lock_fault), .volt_fault(volt_fault)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  // flash model state
  logic [7:0]    sr, next_sr, inj_setup, inj_burst;
  logic [DW-1:0] mem [BW];
  logic [AW-1:0] job_addr, exit_addr;
  logic [DW-1:0] wd0, wd1;
  logic [AW-1:0] wa0, wa1;
  int mode, widx, busy_cnt, all_we, all_re, data_wr, exits, early_wr, post_err_wr;
  int cyc, confirm_cyc, first_re_cyc, inj_burst_at;

  task automatic model_clear();
    sr = 8'h80; next_sr = 8'h80; mode = 0; widx = 0; busy_cnt = 0;
    all_we = 0; all_re = 0; data_wr = 0; exits = 0; early_wr = 0; post_err_wr = 0;
    confirm_cyc = -1; first_re_cyc = -1; exit_addr = '0; job_addr = '0;
    wd0 = '0; wd1 = '0; wa0 = '0; wa1 = '0;
    for (int i = 0; i < BW; i++) mem[i] = 16'h0000;
  endtask

  initial begin
    inj_setup = 8'h00; inj_burst = 8'h00; inj_burst_at = 0; cyc = 0;
    model_clear();
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (fl_re) begin
      fl_rdata <= sr;
      all_re = all_re + 1;
      if (mode == 2 && first_re_cyc < 0) first_re_cyc = cyc;
    end
    if (busy_cnt > 0) begin
      busy_cnt = busy_cnt - 1;
      if (busy_cnt == 0) sr = next_sr;
    end
    if (fl_we) begin
      if (all_we == 0) begin wd0 = fl_wdata; wa0 = fl_addr; end
      if (all_we == 1) begin wd1 = fl_wdata; wa1 = fl_addr; end
      all_we = all_we + 1;
      case (mode)
        0: if (fl_wdata == 16'h0080) begin mode = 1; job_addr = fl_addr; end
        1: if (fl_wdata == 16'h00D0) begin
             confirm_cyc = cyc; sr = 8'h00; busy_cnt = 12; widx = 0;
             if (inj_setup != 8'h00) begin next_sr = inj_setup; mode = 3; end
             else begin next_sr = 8'h01; mode = 2; end
           end
        2: if (fl_addr == job_addr) begin
             if (sr != 8'h01) early_wr = early_wr + 1;
             mem[widx % BW] = fl_wdata;
             widx = widx + 1;
             data_wr = data_wr + 1;
             if (widx % 512 == 0) begin
               sr = 8'h00; busy_cnt = 10;
               if (inj_burst != 8'h00 && widx / 512 == inj_burst_at) begin
                 next_sr = inj_burst; mode = 3;
               end else next_sr = 8'h01;
             end
           end else begin
             exits = exits + 1; exit_addr = fl_addr;
             sr = 8'h00; busy_cnt = 6; next_sr = 8'h80; mode = 0;
           end
        default: post_err_wr = post_err_wr + 1;
      endcase
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  bit stop_src;
  int r_done, r_err, r_status, r_lock, r_volt, r_pulse;

  task automatic src(input int n, input bit gaps);
    for (int i = 0; i < n; i++) begin
      if (stop_src) break;
      if (gaps && (i % 5 == 2)) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_data  = DW'(16'h1000 + i);
      in_last  = (i == n - 1);
      while (!in_ready && !stop_src) @(negedge clk);
      if (stop_src) break;
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic waiter();
    r_done = 0;
    for (int i = 0; i < 30000; i++) begin
      if (done) begin r_done = 1; break; end
      @(negedge clk);
    end
    r_err = int'(err_code); r_status = int'(status);
    r_lock = int'(lock_fault); r_volt = int'(volt_fault);
    @(negedge clk);
    r_pulse = (done == 1'b0);
    stop_src = 1'b1;
  endtask

  task automatic run_job(input logic [AW-1:0] base, input int n, input bit gaps);
    model_clear();
    stop_src = 1'b0;
    @(negedge clk);
    base_addr = base;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    fork
      src(n, gaps);
      waiter();
    join
    repeat (3) @(negedge clk);
  endtask

  task automatic check_data(input int n, input string req);
    int errs = 0, first = -1;
    for (int i = 0; i < n; i++)
      if (mem[i] !== DW'(16'h1000 + i)) begin errs++; if (first < 0) first = i; end
    chk(errs == 0, req, first, -1);
  endtask

  task automatic check_pad(input int from, input int to, input string req);
    int errs = 0;
    for (int i = from; i < to; i++) if (mem[i] !== 16'hFFFF) errs++;
    chk(errs == 0, req, errs, 0);
  endtask

  task automatic t_reset();
    chk(done == 0 && busy == 0, "R10 done/busy", {done, busy}, 0);
    chk(fl_we == 0 && fl_re == 0, "R10 strobes", {fl_we, fl_re}, 0);
    chk(in_ready == 0, "R10 in_ready", in_ready, 0);
    chk(err_code == 0, "R10 err_code", err_code, 0);
  endtask

  task automatic t_misaligned();
    int c = 0;
    model_clear();
    @(negedge clk);
    base_addr = 16'h0105; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1, "R1 done next cycle", done, 1);
    chk(err_code == 2'd1, "R1 err_code", err_code, 1);
    repeat (5) @(negedge clk);
    c = all_we + all_re;
    chk(c == 0, "R1 no flash access", c, 0);
  endtask

  task automatic t_short();
    run_job(16'h0400, 300, 1'b0);
    chk(r_done == 1 && r_pulse == 1, "R9 done pulse", r_done, 1);
    chk(r_err == 0, "R9 err none", r_err, 0);
    chk(r_status == 8'h80, "R9 final status", r_status, 8'h80);
    chk(wd0 == 16'h0080 && wd1 == 16'h00D0, "R2 cmd order", {wd0, wd1}, 32'h008000D0);
    chk(wa0 == 16'h0400 && wa1 == 16'h0400, "R2 cmd address", {wa0, wa1}, 32'h04000400);
    chk(first_re_cyc - confirm_cyc >= DLY, "R3 startup delay", first_re_cyc - confirm_cyc, DLY);
    chk(all_we == 2 + 512 + 1, "R3 no extra writes", all_we, 515);
    chk(data_wr == 512, "R5 one buffer", data_wr, 512);
    check_data(300, "R5 word order");
    check_pad(300, 512, "R5 pad 0xFFFF");
    chk(exits == 1 && exit_addr == 16'h0401, "R9 exit address", exit_addr, 16'h0401);
    chk(early_wr == 0, "R6 R4 data at held address while available", early_wr, 0);
  endtask

  task automatic t_multi();
    run_job(16'h0000, 700, 1'b1);
    chk(r_err == 0 && r_done == 1, "R5 multi done", r_err, 0);
    chk(data_wr == 1024, "R5 two buffers", data_wr, 1024);
    check_data(700, "R5 word order gaps");
    check_pad(700, 1024, "R5 pad tail");
    chk(early_wr == 0, "R4 no write while busy", early_wr, 0);
  endtask

  task automatic t_exact();
    run_job(16'h0200, 512, 1'b0);
    chk(data_wr == 512, "R5 exact no pad buffer", data_wr, 512);
    chk(mem[511] == 16'h11FF, "R5 last word", mem[511], 16'h11FF);
    chk(r_err == 0, "R9 exact ok", r_err, 0);
  endtask

  task automatic t_setup_err(input logic [7:0] code, input int lk, input int vt);
    inj_setup = code;
    run_job(16'h0000, 100, 1'b0);
    inj_setup = 8'h00;
    chk(r_err == 2, "R7 device error", r_err, 2);
    chk(r_status == int'(code), "R7 status byte", r_status, code);
    chk(r_lock == lk && r_volt == vt, "R7 cause bits", {r_lock, r_volt}, {lk, vt});
    chk(data_wr == 0 && post_err_wr == 0, "R7 no writes after fail", post_err_wr + data_wr, 0);
  endtask

  task automatic t_burst_err();
    inj_burst = 8'h10; inj_burst_at = 1;
    run_job(16'h0000, 700, 1'b0);
    inj_burst = 8'h00; inj_burst_at = 0;
    chk(r_err == 2, "R7 error after buffer", r_err, 2);
    chk(data_wr == 512 && post_err_wr == 0, "R7 stop after buffer", data_wr + post_err_wr, 512);
    chk(r_lock == 0 && r_volt == 0, "R7 plain failure", {r_lock, r_volt}, 0);
  endtask

  task automatic t_overflow();
    run_job(16'h0000, 1100, 1'b0);
    chk(r_err == 3, "R8 overflow code", r_err, 3);
    chk(data_wr == BW, "R8 block filled", data_wr, BW);
    chk(exits == 1, "R8 mode exited", exits, 1);
    check_data(BW, "R8 data kept");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_misaligned();
    t_short();
    t_multi();
    t_exact();
    t_setup_err(8'h12, 1, 0);
    t_setup_err(8'h18, 0, 1);
    t_burst_err();
    t_overflow();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule